// File: doc/BRIEF.md
# SPI-4.2 Status Calendar Receiver

This block sits behind the physical capture of the SPI-4.2 FIFO status lane. Each cycle of the status clock it takes one 2-bit word. It hunts for a framing word, then steps through a programmable calendar of channel numbers and records the status word given for each slot. The pass ends with a DIP-2 check word. A pass whose check word matches is committed to the status store. A pass whose check word does not match is discarded, and a sticky error flag is raised.

Each accepted status word is also reported on the status clock. An output names the channel it was written for, and a qualifier marks that output valid. The qualifier stays low for framing words, check words and any word seen while hunting.

Committed status moves to an independent read clock as a whole snapshot, using a toggle handshake with two-flop synchronisers. On that clock, a bank address selects a 32-bit word that holds sixteen channels.

Top module: `spi4_stat_cal_rx`

## Requirements
- R1: After reset, and after any loss of sync, words are ignored until a framing word (code 11) is sampled. Ignored words raise no qualifier and change no stored status.
- R2: Word k of a pass (k counted from 0) is stored for the channel held in calendar entry k, at `cal_seq_i[k*CH_W +: CH_W]`. A pass holds exactly `cal_len_i` words, with a length from 1 to CAL_MAX. Every pass restarts at entry 0.
- R3: One status-clock cycle after a status word is sampled, `ch_vld_o` is high and `ch_o` holds that word's channel. After a framing word, a check word or a word ignored while hunting, `ch_vld_o` is low.
- R4: The word after the last calendar slot is the check word. It must equal the bitwise inverse of the XOR of all status words in the pass. On a match, the whole pass is committed.
- R5: On a check mismatch, none of that pass's updates are committed, and `dip_err_o` goes high and stays high until reset.
- R6: Read bank b holds channel 16*b+n at bits [2n+1:2n]. The codes are 00 starving, 01 hungry and 10 satisfied. Every channel reads 00 after reset.
- R7: When one channel appears in several slots of a pass, the last slot's word is the one committed.
- R8: A code 11 in a status slot drops the current pass uncommitted and returns to hunting. That 11 does not itself start a pass.
- R9: Repeated framing words before a pass are accepted as idle framing. The pass starts at the first non-11 word.
- R10: A committed pass appears in the read domain as one whole snapshot. `rd_data_o` shows the addressed bank one read-clock cycle after `rd_bank_i` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| stat_clk_i | input | 1 | Status lane clock |
| rst_ni | input | 1 | Active-low async reset, status domain |
| stat_i | input | 2 | Received status word |
| cal_len_i | input | $clog2(CAL_MAX+1) (5) | Calendar length, 1..CAL_MAX |
| cal_seq_i | input | CAL_MAX*CH_W (128) | Calendar entries, packed channel numbers |
| ch_o | output | CH_W (8) | Channel of the last accepted status word |
| ch_vld_o | output | 1 | Qualifier for ch_o |
| dip_err_o | output | 1 | Sticky check-word mismatch flag |
| rd_clk_i | input | 1 | Read-side clock |
| rd_rst_ni | input | 1 | Active-low async reset, read domain |
| rd_bank_i | input | BANK_W (4) | Bank address |
| rd_data_o | output | 32 | Bank word, 2 bits per channel |

## Verification
The bench builds the block with NUM_CH=32 and CAL_MAX=8, which gives two banks and five-bit channel numbers. With that size, the sweep passes can write every channel with every status code over several rounds. Both banks are read back after each round, against a model kept in the bench. The small calendar also brings within reach the one-slot pass, a full eight-slot pass, repeated channels in one pass, a corrupted check word, and a framing code in the middle of a pass.

// File: rtl/spi4_stat_pkg.sv
`timescale 1ns/1ps
package spi4_stat_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_FRAME, ST_CAL, ST_DIP} sc_state_e;
  localparam logic [1:0] CODE_FRAME = 2'b11;
  localparam int unsigned CH_PER_BANK = 16;
endpackage

// File: rtl/sc_cal_seq.sv
`timescale 1ns/1ps
module sc_cal_seq
  import spi4_stat_pkg::*;
#(
  parameter int unsigned CAL_MAX = 16,
  parameter int unsigned CH_W    = 8,
  parameter int unsigned LEN_W   = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              stat_i,
  input  logic [LEN_W-1:0]        cal_len_i,
  input  logic [CAL_MAX*CH_W-1:0] cal_seq_i,
  output logic                    load_o,
  output logic                    wr_o,
  output logic [CH_W-1:0]         wr_ch_o,
  output logic [1:0]              wr_code_o,
  output logic                    commit_o,
  output logic [CH_W-1:0]         ch_o,
  output logic                    ch_vld_o,
  output logic                    dip_err_o
);
  sc_state_e        state_q, state_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic [1:0]       dip_q, dip_d;
  logic             is_frame, last_slot, dip_ok;
  logic [CH_W-1:0]  cur_ch, ch_q;
  logic             vld_q, err_q;

  assign cur_ch    = cal_seq_i[int'(idx_q)*CH_W +: CH_W];
  assign is_frame  = (stat_i == CODE_FRAME);
  assign last_slot = (idx_q == cal_len_i - LEN_W'(1));
  assign dip_ok    = (stat_i == ~dip_q);

  assign wr_o      = ((state_q == ST_FRAME) || (state_q == ST_CAL)) && !is_frame;
  assign wr_ch_o   = cur_ch;
  assign wr_code_o = stat_i;
  assign load_o    = (state_q == ST_HUNT) || (state_q == ST_FRAME);
  assign commit_o  = (state_q == ST_DIP) && dip_ok;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    dip_d   = dip_q;
    unique case (state_q)
      ST_HUNT: if (is_frame) state_d = ST_FRAME;
      ST_FRAME: begin
        if (!is_frame) begin
          dip_d   = stat_i;
          idx_d   = LEN_W'(1);
          state_d = last_slot ? ST_DIP : ST_CAL;
        end
      end
      ST_CAL: begin
        if (is_frame) begin
          // framing code inside a pass: sync lost
          state_d = ST_HUNT;
          idx_d   = '0;
        end else begin
          dip_d   = dip_q ^ stat_i;
          idx_d   = idx_q + LEN_W'(1);
          state_d = last_slot ? ST_DIP : ST_CAL;
        end
      end
      ST_DIP: begin
        state_d = ST_HUNT;
        idx_d   = '0;
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      idx_q   <= '0;
      dip_q   <= '0;
      ch_q    <= '0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      dip_q   <= dip_d;
      vld_q   <= wr_o;
      if (wr_o) ch_q <= cur_ch;
      if ((state_q == ST_DIP) && !dip_ok) err_q <= 1'b1;
    end
  end

  assign ch_o      = ch_q;
  assign ch_vld_o  = vld_q;
  assign dip_err_o = err_q;
endmodule

// File: rtl/sc_stat_store.sv
`timescale 1ns/1ps
module sc_stat_store #(
  parameter int unsigned NUM_CH = 256,
  parameter int unsigned CH_W   = 8,
  localparam int unsigned MEM_W = 2 * NUM_CH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             wr_i,
  input  logic [CH_W-1:0]  wr_ch_i,
  input  logic [1:0]       wr_code_i,
  input  logic             commit_i,
  output logic [MEM_W-1:0] com_o
);
  logic [MEM_W-1:0] shd_q, com_q;

  // shadow tracks committed state between passes; slot writes override
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= '0;
      com_q <= '0;
    end else begin
      if (load_i) shd_q <= com_q;
      if (wr_i) shd_q[int'(wr_ch_i)*2 +: 2] <= wr_code_i;
      if (commit_i) com_q <= shd_q;
    end
  end

  assign com_o = com_q;
endmodule

// File: rtl/sc_stat_xfer.sv
`timescale 1ns/1ps
module sc_stat_xfer #(
  parameter int unsigned NUM_CH = 256,
  parameter int unsigned BANK_W = 4,
  localparam int unsigned MEM_W = 2 * NUM_CH
) (
  input  logic              src_clk_i,
  input  logic              src_rst_ni,
  input  logic              commit_i,
  input  logic [MEM_W-1:0]  com_i,
  input  logic              dst_clk_i,
  input  logic              dst_rst_ni,
  input  logic [BANK_W-1:0] bank_i,
  output logic [31:0]       data_o
);
  logic             dirty_q, req_q, ack_s1_q, ack_s2_q, busy;
  logic [MEM_W-1:0] hold_q;
  logic             req_s1_q, req_s2_q, req_s3_q;
  logic [MEM_W-1:0] mem_q;
  logic [31:0]      data_q;

  assign busy = (req_q != ack_s2_q);

  always_ff @(posedge src_clk_i or negedge src_rst_ni) begin
    if (!src_rst_ni) begin
      dirty_q  <= 1'b0;
      req_q    <= 1'b0;
      ack_s1_q <= 1'b0;
      ack_s2_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      ack_s1_q <= req_s3_q;
      ack_s2_q <= ack_s1_q;
      if (dirty_q && !busy) begin
        hold_q  <= com_i;
        req_q   <= ~req_q;
        dirty_q <= commit_i;
      end else if (commit_i) begin
        dirty_q <= 1'b1;
      end
    end
  end

  // hold_q is stable while req and ack differ
  always_ff @(posedge dst_clk_i or negedge dst_rst_ni) begin
    if (!dst_rst_ni) begin
      req_s1_q <= 1'b0;
      req_s2_q <= 1'b0;
      req_s3_q <= 1'b0;
      mem_q    <= '0;
      data_q   <= '0;
    end else begin
      req_s1_q <= req_q;
      req_s2_q <= req_s1_q;
      req_s3_q <= req_s2_q;
      if (req_s2_q != req_s3_q) mem_q <= hold_q;
      data_q <= mem_q[int'(bank_i)*32 +: 32];
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/spi4_stat_cal_rx.sv
`timescale 1ns/1ps
module spi4_stat_cal_rx
  import spi4_stat_pkg::*;
#(
  parameter int unsigned NUM_CH  = 256,
  parameter int unsigned CAL_MAX = 16,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned LEN_W  = $clog2(CAL_MAX + 1),
  localparam int unsigned BANKS  = NUM_CH / CH_PER_BANK,
  localparam int unsigned BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                    stat_clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              stat_i,
  input  logic [LEN_W-1:0]        cal_len_i,
  input  logic [CAL_MAX*CH_W-1:0] cal_seq_i,
  output logic [CH_W-1:0]         ch_o,
  output logic                    ch_vld_o,
  output logic                    dip_err_o,
  input  logic                    rd_clk_i,
  input  logic                    rd_rst_ni,
  input  logic [BANK_W-1:0]       rd_bank_i,
  output logic [31:0]             rd_data_o
);
  logic              load, wr, commit;
  logic [CH_W-1:0]   wr_ch;
  logic [1:0]        wr_code;
  logic [2*NUM_CH-1:0] com;

  sc_cal_seq #(.CAL_MAX(CAL_MAX), .CH_W(CH_W), .LEN_W(LEN_W)) u_seq (
    .clk_i(stat_clk_i), .rst_ni(rst_ni), .stat_i(stat_i),
    .cal_len_i(cal_len_i), .cal_seq_i(cal_seq_i),
    .load_o(load), .wr_o(wr), .wr_ch_o(wr_ch), .wr_code_o(wr_code),
    .commit_o(commit), .ch_o(ch_o), .ch_vld_o(ch_vld_o), .dip_err_o(dip_err_o)
  );

  sc_stat_store #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_store (
    .clk_i(stat_clk_i), .rst_ni(rst_ni), .load_i(load), .wr_i(wr),
    .wr_ch_i(wr_ch), .wr_code_i(wr_code), .commit_i(commit), .com_o(com)
  );

  sc_stat_xfer #(.NUM_CH(NUM_CH), .BANK_W(BANK_W)) u_xfer (
    .src_clk_i(stat_clk_i), .src_rst_ni(rst_ni), .commit_i(commit), .com_i(com),
    .dst_clk_i(rd_clk_i), .dst_rst_ni(rd_rst_ni), .bank_i(rd_bank_i),
    .data_o(rd_data_o)
  );
endmodule

// File: rtl/spi4_stat_cal_rx_chk.sv
`timescale 1ns/1ps
module spi4_stat_cal_rx_chk #(
  parameter int unsigned CAL_MAX = 16,
  localparam int unsigned CNT_W  = $clog2(CAL_MAX + 2)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] stat_i,
  input logic       ch_vld_o,
  input logic       dip_err_o
);
  logic             seen_q;
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      run_q  <= '0;
    end else begin
      if (stat_i == 2'b11) seen_q <= 1'b1;
      if (ch_vld_o) run_q <= run_q + CNT_W'(1);
      else          run_q <= '0;
    end
  end

  a_r1_quiet_until_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_vld_o |-> seen_q);

  a_r8_frame_no_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i == 2'b11) |=> !ch_vld_o);

  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dip_err_o |=> dip_err_o);

  a_r2_vld_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_vld_o |-> (run_q < CNT_W'(CAL_MAX)));
endmodule

bind spi4_stat_cal_rx spi4_stat_cal_rx_chk #(.CAL_MAX(CAL_MAX)) u_chk (
  .clk_i(stat_clk_i), .rst_ni(rst_ni), .stat_i(stat_i),
  .ch_vld_o(ch_vld_o), .dip_err_o(dip_err_o)
);

// File: tb/sim_spi4_stat_cal_rx.sv
`timescale 1ns/1ps
module sim_spi4_stat_cal_rx;
  localparam int NUM_CH  = 32;
  localparam int CAL_MAX = 8;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int LEN_W   = $clog2(CAL_MAX + 1);
  localparam int BANKS   = NUM_CH / 16;
  localparam int BANK_W  = (BANKS > 1) ? $clog2(BANKS) : 1;

  logic                    stat_clk = 0, rd_clk = 0;
  logic                    rst_ni = 0, rd_rst_ni = 0;
  logic [1:0]              stat_i = 2'b00;
  logic [LEN_W-1:0]        cal_len = '0;
  logic [CAL_MAX*CH_W-1:0] cal_seq = '0;
  logic [CH_W-1:0]         ch_o;
  logic                    ch_vld_o, dip_err_o;
  logic [BANK_W-1:0]       rd_bank = '0;
  logic [31:0]             rd_data;

  int total = 0, bad = 0;
  int seq_a [CAL_MAX];
  logic [1:0] codes_a [CAL_MAX];
  logic [1:0] mdl [NUM_CH];

  always #5 stat_clk = ~stat_clk;
  always #7 rd_clk = ~rd_clk;

  spi4_stat_cal_rx #(.NUM_CH(NUM_CH), .CAL_MAX(CAL_MAX)) u0 (
    .stat_clk_i(stat_clk), .rst_ni(rst_ni), .stat_i(stat_i),
    .cal_len_i(cal_len), .cal_seq_i(cal_seq), .ch_o(ch_o),
    .ch_vld_o(ch_vld_o), .dip_err_o(dip_err_o), .rd_clk_i(rd_clk),
    .rd_rst_ni(rd_rst_ni), .rd_bank_i(rd_bank), .rd_data_o(rd_data)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] w, input logic exp_vld, input int exp_ch, input string rq);
    @(negedge stat_clk) stat_i = w;
    @(posedge stat_clk);
    #2;
    check(rq, 32'(ch_vld_o), 32'(exp_vld));
    if (exp_vld) check(rq, 32'(ch_o), 32'(exp_ch));
  endtask

  task automatic load_cal(input int len);
    cal_len = LEN_W'(len);
    for (int k = 0; k < CAL_MAX; k++) cal_seq[k*CH_W +: CH_W] = CH_W'(seq_a[k]);
  endtask

  // frames: number of framing words; good=0 corrupts check word
  task automatic run_pass(input int len, input int frames, input bit good);
    logic [1:0] x;
    load_cal(len);
    for (int f = 0; f < frames; f++) send(2'b11, 1'b0, 0, "R9 framing");
    x = 2'b00;
    for (int k = 0; k < len; k++) begin
      send(codes_a[k], 1'b1, seq_a[k], "R3 slot report");
      x = x ^ codes_a[k];
    end
    x = ~x;
    if (!good) x = x ^ 2'b01;
    send(x, 1'b0, 0, "R3 check word quiet");
    if (good) for (int k = 0; k < len; k++) mdl[seq_a[k]] = codes_a[k];
    repeat (12) @(posedge rd_clk);
  endtask

  task automatic check_banks(input string rq);
    logic [31:0] e;
    for (int b = 0; b < BANKS; b++) begin
      e = '0;
      for (int n = 0; n < 16; n++) e[2*n +: 2] = mdl[16*b+n];
      @(negedge rd_clk) rd_bank = BANK_W'(b);
      @(posedge rd_clk);
      #1;
      check(rq, rd_data, e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge stat_clk);
    total++; bad++;
    $display("FAIL all watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NUM_CH; c++) mdl[c] = 2'b00;
    for (int k = 0; k < CAL_MAX; k++) begin seq_a[k] = 0; codes_a[k] = 2'b00; end
    repeat (3) @(posedge stat_clk);
    @(negedge stat_clk) begin rst_ni = 1; rd_rst_ni = 1; end
    #2;
    check("R3 reset vld", 32'(ch_vld_o), 0);
    check("R5 reset err", 32'(dip_err_o), 0);
    check_banks("R6 reset banks");

    // R1: words before any framing are ignored
    send(2'b10, 1'b0, 0, "R1 hunt");
    send(2'b01, 1'b0, 0, "R1 hunt");
    send(2'b10, 1'b0, 0, "R1 hunt");
    repeat (12) @(posedge rd_clk);
    check_banks("R1 hunt no store");

    // R2/R6: length-6 calendar 0,1,2,3,0,1; satisfied spreads over ch0..2
    seq_a[0]=0; seq_a[1]=1; seq_a[2]=2; seq_a[3]=3; seq_a[4]=0; seq_a[5]=1;
    seq_a[6]=9; seq_a[7]=9;
    codes_a[0]=2'b10; codes_a[1]=2'b00; codes_a[2]=2'b00; codes_a[3]=2'b00;
    codes_a[4]=2'b10; codes_a[5]=2'b00;
    run_pass(6, 1, 1'b1);
    check_banks("R2 pass one");
    @(negedge rd_clk) rd_bank = '0;
    @(posedge rd_clk); #1;
    check("R6 bank0 value", rd_data, 32'h2);
    codes_a[1]=2'b10; codes_a[5]=2'b10;
    run_pass(6, 1, 1'b1);
    @(negedge rd_clk) rd_bank = '0;
    @(posedge rd_clk); #1;
    check("R6 bank0 value", rd_data, 32'hA);
    codes_a[2]=2'b10;
    run_pass(6, 1, 1'b1);
    @(negedge rd_clk) rd_bank = '0;
    @(posedge rd_clk); #1;
    check("R10 bank0 value", rd_data, 32'h2A);

    // R7: repeated channel, last slot wins
    seq_a[0]=5; seq_a[1]=5; seq_a[2]=20; seq_a[3]=20;
    codes_a[0]=2'b01; codes_a[1]=2'b10; codes_a[2]=2'b10; codes_a[3]=2'b01;
    run_pass(4, 1, 1'b1);
    check_banks("R7 last wins");

    // R5: corrupted check word
    seq_a[0]=6; seq_a[1]=7; seq_a[2]=17;
    codes_a[0]=2'b01; codes_a[1]=2'b10; codes_a[2]=2'b01;
    run_pass(3, 1, 1'b0);
    check("R5 err set", 32'(dip_err_o), 1);
    check_banks("R5 pass discarded");
    run_pass(3, 1, 1'b1);
    check("R5 err sticky", 32'(dip_err_o), 1);
    check_banks("R4 good pass commits");

    // R8: framing code inside a pass
    seq_a[0]=10; seq_a[1]=11; seq_a[2]=12; seq_a[3]=13;
    load_cal(4);
    send(2'b11, 1'b0, 0, "R8 frame");
    send(2'b01, 1'b1, 10, "R8 slot0");
    send(2'b10, 1'b1, 11, "R8 slot1");
    send(2'b11, 1'b0, 0, "R8 abort quiet");
    send(2'b01, 1'b0, 0, "R8 hunting after abort");
    send(2'b10, 1'b0, 0, "R8 hunting after abort");
    repeat (12) @(posedge rd_clk);
    check_banks("R8 no commit");

    // R9: repeated framing, R2: one-slot calendar
    seq_a[0]=31; codes_a[0]=2'b01;
    run_pass(1, 3, 1'b1);
    check_banks("R9 len1 after idle framing");

    // R2/R6 sweep: every channel, every code, both banks
    for (int r = 0; r < 3; r++) begin
      for (int g = 0; g < NUM_CH / CAL_MAX; g++) begin
        for (int k = 0; k < CAL_MAX; k++) begin
          seq_a[k] = g*CAL_MAX + k;
          codes_a[k] = 2'((g*CAL_MAX + k + r) % 3);
        end
        run_pass(CAL_MAX, 1, 1'b1);
      end
      check_banks("R6 sweep");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule